// File: doc/BRIEF.md
# Dual-Mode UART Baud Generator

This block derives the 16x oversampling strobe for a UART transmitter and receiver from the system clock. It has two engines, and one mode input selects which of them drives the strobe.

The first engine is a reload counter. It fires once every N clocks, where N is the rate word and N is computed as clock / (16 × baud). The second engine is a 16-bit phase accumulator. Each clock it adds the rate word, and each carry out of the accumulator is a strobe, so the rate word is baud × 16 × 2^16 / clock. The accumulator gives finer rate steps than the counter at high bit rates.

A divide-by-16 prescaler follows the selected strobe and produces one pulse per bit time. When the run input is low, every engine and the prescaler are held cleared. Software drops run while it reprograms the rate word, and each restart then follows the same cycle sequence.

Top module: `baud_gen_dual`

## Requirements
- R1: While reset is asserted, and until run_i is raised, both os_tick_o and bit_tick_o are 0.
- R2: With frac_mode_i = 0 and a rate word N ≥ 2, os_tick_o is a single-cycle pulse once every N clocks. Over a window of W cycles, the pulse count is W/N ± 1.
- R3: With frac_mode_i = 0 and a rate word of 0 or 1, os_tick_o is high on every clock and never stalls.
- R4: With frac_mode_i = 1, the accumulator adds the rate word R each clock, and os_tick_o pulses on each carry out of bit 15. The count over W cycles is W·R/65536 ± 1, and R = 0 gives no pulses.
- R5: While run_i is low, no pulses appear, and the counter, the accumulator and the prescaler are cleared to zero. After run_i rises, the counter engine sets its first pulse at the N-th enabled clock edge, so the pulse is visible for the clock cycle that follows that edge.
- R6: bit_tick_o is a single-cycle pulse. It is registered one clock after every 16th os_tick_o pulse, counted from the moment run_i was raised.
- R7: frac_mode_i = 1 selects the accumulator and frac_mode_i = 0 selects the counter. The engine that is not selected is held cleared, so a mode change restarts the newly selected engine from zero. The prescaler count is kept across a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Generator enable; low clears all state |
| frac_mode_i | input | 1 | 1 selects the phase accumulator, 0 selects the reload counter |
| rate_i | input | 16 | Rate word: the reload count or the phase increment |
| os_tick_o | output | 1 | 16x oversample strobe |
| bit_tick_o | output | 1 | One pulse per bit time |

## Verification
The bench builds the block with its default parameters: a 16-bit rate word and accumulator, and an oversampling ratio of 16. With a 16-bit accumulator, a rate word of 0x4000 gives an exact quarter-rate strobe, and 0x1234 gives a fractional rate. The window counts can then be checked against the formulas with exact integer arithmetic. A ratio of 16 keeps the bit-tick period short, so several prescaler wraps, a mode change in the middle of a run, and restarts after run is dropped all fit into a few thousand cycles.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    ENG_DIV = 1'b0,
    ENG_ACC = 1'b1
  } engine_e;
endpackage

// File: rtl/baud_div.sv
module baud_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] rate_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         last;

  // rate 0/1 collapse to every clock; >= guards a rate shrunk mid-count
  assign last = (rate_i <= W'(1)) || (cnt_q >= rate_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (last) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + W'(1);
      tick_o <= 1'b0;
    end
  end

  a_r3_min_rate_every_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rate_i <= W'(1)) |=> tick_o);

  a_r5_div_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_o && cnt_q == '0));

  a_r2_div_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && rate_i >= W'(2) && $stable(rate_i)) |-> (cnt_q < rate_i));
endmodule

// File: rtl/baud_acc.sv
module baud_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] rate_i,
  output logic         tick_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, rate_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= sum[W-1:0];
      tick_o <= sum[W];
    end
  end

  a_r4_zero_rate_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rate_i == '0) |=> !tick_o);

  a_r5_acc_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_o && acc_q == '0));
endmodule

// File: rtl/baud_presc.sv
module baud_presc #(
  parameter int unsigned OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic os_i,
  output logic bit_tick_o
);
  localparam int unsigned PW = (OSR > 1) ? $clog2(OSR) : 1;

  logic [PW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      bit_tick_o <= 1'b0;
    end else if (!en_i) begin
      pc_q       <= '0;
      bit_tick_o <= 1'b0;
    end else if (os_i) begin
      if (pc_q == PW'(OSR - 1)) begin
        pc_q       <= '0;
        bit_tick_o <= 1'b1;
      end else begin
        pc_q       <= pc_q + PW'(1);
        bit_tick_o <= 1'b0;
      end
    end else begin
      bit_tick_o <= 1'b0;
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o);

  a_r6_needs_os: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bit_tick_o) |-> $past(os_i));
endmodule

// File: rtl/baud_gen_dual.sv
module baud_gen_dual
  import baud_pkg::*;
#(
  parameter int unsigned RATE_W = 16,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              frac_mode_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              os_tick_o,
  output logic              bit_tick_o
);
  engine_e eng;
  logic    div_en, acc_en, div_tick, acc_tick;

  assign eng    = engine_e'(frac_mode_i);
  assign div_en = run_i && (eng == ENG_DIV);
  assign acc_en = run_i && (eng == ENG_ACC);

  baud_div #(.W(RATE_W)) u_div (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (div_en),
    .rate_i (rate_i), .tick_o (div_tick)
  );

  baud_acc #(.W(RATE_W)) u_acc (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (acc_en),
    .rate_i (rate_i), .tick_o (acc_tick)
  );

  assign os_tick_o = (eng == ENG_ACC) ? acc_tick : div_tick;

  baud_presc #(.OSR(OSR)) u_presc (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (run_i),
    .os_i (os_tick_o), .bit_tick_o (bit_tick_o)
  );

  a_r7_idle_engine_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({div_tick, acc_tick}) || (div_tick && acc_tick && 1'b0) || !(div_tick && acc_tick));

  a_r5_stopped_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!os_tick_o && !bit_tick_o));
endmodule

// File: tb/sim_baud_gen_dual.sv
module sim_baud_gen_dual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] rate = 16'd0;
  logic        os_tick, bit_tick;

  int vectors = 0;
  int errors  = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  baud_gen_dual u0 (
    .clk_i (clk), .rst_ni (rst_n), .run_i (run), .frac_mode_i (mode),
    .rate_i (rate), .os_tick_o (os_tick), .bit_tick_o (bit_tick)
  );

  // behavioural reference
  int m_cnt = 0, m_acc = 0, m_pc = 0;
  bit m_dt = 0, m_at = 0, m_bt = 0;

  always @(posedge clk or negedge rst_n) begin
    bit os_now;
    int n;
    if (!rst_n) begin
      m_cnt = 0; m_acc = 0; m_pc = 0; m_dt = 0; m_at = 0; m_bt = 0;
    end else begin
      os_now = mode ? m_at : m_dt;
      n = (rate <= 1) ? 1 : int'(rate);
      if (!(run && !mode)) begin m_cnt = 0; m_dt = 0; end
      else if (m_cnt + 1 >= n) begin m_cnt = 0; m_dt = 1; end
      else begin m_cnt = m_cnt + 1; m_dt = 0; end
      if (!(run && mode)) begin m_acc = 0; m_at = 0; end
      else begin
        m_acc = m_acc + int'(rate);
        m_at  = (m_acc >= 65536);
        m_acc = m_acc % 65536;
      end
      if (!run) begin m_pc = 0; m_bt = 0; end
      else if (os_now) begin
        if (m_pc == 15) begin m_pc = 0; m_bt = 1; end
        else begin m_pc = m_pc + 1; m_bt = 0; end
      end else m_bt = 0;
    end
  end

  int win_os = 0, win_bit = 0;

  // per-cycle compare, away from the edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n) begin
        bit exp_os;
        exp_os = mode ? m_at : m_dt;
        vectors++;
        if (os_tick !== exp_os) begin
          errors++;
          $display("FAIL %s os_tick actual %0b expected %0b at %0t", cur_req, os_tick, exp_os, $time);
        end
        vectors++;
        if (bit_tick !== m_bt) begin
          errors++;
          $display("FAIL %s bit_tick actual %0b expected %0b at %0t", cur_req, bit_tick, m_bt, $time);
        end
        if (os_tick === 1'b1) win_os++;
        if (bit_tick === 1'b1) win_bit++;
      end
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic window(input string req, input int w, input int exp_os, input int exp_bit);
    win_os = 0; win_bit = 0;
    cycles(w);
    vectors++;
    if (win_os < exp_os - 1 || win_os > exp_os + 1) begin
      errors++;
      $display("FAIL %s window os count actual %0d expected %0d", req, win_os, exp_os);
    end
    if (exp_bit >= 0) begin
      vectors++;
      if (win_bit < exp_bit - 1 || win_bit > exp_bit + 1) begin
        errors++;
        $display("FAIL %s window bit count actual %0d expected %0d", req, win_bit, exp_bit);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset and idle
    cur_req = "R1";
    #23; rst_n = 1'b1;
    cycles(8);
    vectors++;
    if (os_tick !== 1'b0 || bit_tick !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle outputs actual %0b%0b expected 00", os_tick, bit_tick);
    end

    // R2 reload counter, N=5
    cur_req = "R2";
    mode = 1'b0; rate = 16'd5; run = 1'b1;
    cycles(20);
    window("R2", 1000, 200, 12);

    // R2 N=37
    rate = 16'd37;
    cycles(40);
    window("R2", 1480, 40, 2);

    // R3 rate 0 and 1
    cur_req = "R3";
    rate = 16'd0;
    cycles(2);
    window("R3", 100, 100, 6);
    rate = 16'd1;
    cycles(2);
    window("R3", 100, 100, 6);

    // R5 stop then deterministic restart
    cur_req = "R5";
    run = 1'b0;
    cycles(2);
    window("R5", 50, 0, 0);
    rate = 16'd7; run = 1'b1;
    win_os = 0;
    cycles(7);
    vectors++;
    if (win_os != 1) begin
      errors++;
      $display("FAIL R5 first tick after restart actual %0d expected 1", win_os);
    end

    // R4 accumulator
    cur_req = "R4";
    mode = 1'b1; rate = 16'h4000;
    cycles(8);
    window("R4", 1024, 256, 16);
    rate = 16'h1234;
    cycles(8);
    window("R4", 4096, 291, 18);
    rate = 16'h0000;
    cycles(2);
    window("R4", 200, 0, 0);

    // R7 mode changes mid-run, R6 bit ticks across them
    cur_req = "R7";
    rate = 16'd3;
    for (int k = 0; k < 6; k++) begin
      mode = ~mode;
      cycles(45);
    end
    cur_req = "R6";
    mode = 1'b0; rate = 16'd2;
    cycles(4);
    window("R6", 640, 320, 20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule